// File: doc/BRIEF.md
# Register Sequencer with Paged Memory Cursor

This block sits behind a byte-level serial-bus slave front end that has already handled the bit-level signalling. The front end reports four kinds of event: a start with the address matched (with a read/write flag), a data byte written, a data byte requested for reading, and a stop. The first byte written after a write start picks a register address. Each later byte goes to that register, and the register address then moves on according to a rule that depends on the register. Some registers hold the address in place. Two indexed registers advance an internal index instead of the register address.

The block keeps a page/row/column cursor into an external paged text memory. It reaches that memory through a simple request/acknowledge port, and it stalls the front end (`busy`) until each request is acknowledged. A mode bit redirects the data address to a read-only status byte. The block also holds a seven-byte page-request register and an eight-entry table of 7-bit page pointers. All register contents are brought out as flat buses so that neighbouring logic can decode them.

Top module: `regseq_top`

## Requirements
- R1: After reset, control bytes 0–4 and 7–12 read 0x00, bytes 5 and 6 read 0x03, pointer entry n holds n for n = 0..7, all request bytes are 0x00, and `busy`, `mem_req` and `clr_pulse` are low.
- R2: The first byte written after a write start sets the register address. Values above 13 select no register, so later bytes are discarded. A data byte written to register 0, 1, 2, 4, 5, 6, 8, 9, 10 or 12 is stored and moves the register address up by one.
- R3: After a byte is written to register 3, 7, 11 or 13, the register address stays where it is. A run of bytes to register 7 leaves only the last one stored.
- R4: Register 3 is seven bytes wide. A write goes to the byte selected by bits 2:0 of control byte 2, and then that index steps up, with 6 wrapping to 0. When the index is 7, the byte is discarded and the index becomes 0.
- R5: A write to register 13 stores bits 6:0 in the pointer entry selected by bits 2:0 of control byte 12. Those three bits then step up modulo 8, and bits 7:3 of byte 12 are left unchanged.
- R6: Each access to the data address moves the cursor one column on. A column of 39 or more goes to 0 and advances the row, and a row of 23 or more goes to 0. Row 9 stores bits 4:0 and column 10 stores bits 5:0 of the written byte, which is how rows 24 and 25 are reached.
- R7: When bit 0 of control byte 0 is clear, a byte written to address 11 raises a write request. The request carries page = bits 6:0 of byte 8, the cursor row and column, and the byte. Its payload is held, and `busy` stays high, until `mem_ack`. The cursor advances on the acknowledge.
- R8: When bit 0 of control byte 0 is set, reading address 11 returns `status_in`. A write to address 11 then raises no request and leaves the cursor unchanged.
- R9: With the mode bit clear, writing address byte 11, or writing register 10, fetches the byte at the cursor ahead of time. Each read of address 11 returns the fetched byte, advances the cursor and fetches again. Reading any other address returns 0x00.
- R10: A write to register 8 stores bits 6:0 as the access page. Bit 7 is not stored: when it is set, `clr_pulse` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start with matched device address |
| ev_read | input | 1 | Direction of the start, 1 = read |
| ev_wr | input | 1 | A written byte is on `wr_byte` |
| ev_rd | input | 1 | Front end takes `rd_byte` this cycle |
| ev_stop | input | 1 | Stop condition |
| wr_byte | input | 8 | Written byte |
| rd_byte | output | 8 | Byte offered for reading |
| busy | output | 1 | Stall: a memory request is pending |
| status_in | input | 8 | Status byte shown at address 11 in status mode |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request |
| mem_page | output | 7 | Request page |
| mem_row | output | 5 | Request row |
| mem_col | output | 6 | Request column |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Request accepted, one cycle |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| clr_pulse | output | 1 | One-shot page clear command |
| ctl_q | output | 104 | Control bytes 0..12, byte i at bits 8i+7:8i (row and column zero-extended) |
| req_q | output | 56 | Page-request bytes 0..6 |
| ptr_q | output | 56 | Page pointers 0..7, 7 bits each |

## Verification
On every cycle, the assertions check these rules:
- how the register address advances or holds after each data byte;
- that the pointer index steps up;
- that each cursor step is a single column increment or a wrap;
- that the request payload is stable until it is acknowledged;
- that status mode raises no request;
- that the clear command lasts one cycle.

Only the bench scenarios can show what ends up stored:
- reset values and the indexed byte placement, including the discarded index-7 write;
- the long write and read sweeps across the column-39 and row-23 wraps, with data checked against a computed memory pattern;
- the row-24 corner, status-mode reads, and reads of non-data addresses.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

  localparam logic [3:0] REG_MODE   = 4'd0;
  localparam logic [3:0] REG_REQIDX = 4'd2;
  localparam logic [3:0] REG_REQ    = 4'd3;
  localparam logic [3:0] REG_PAGE   = 4'd8;
  localparam logic [3:0] REG_ROW    = 4'd9;
  localparam logic [3:0] REG_COL    = 4'd10;
  localparam logic [3:0] REG_DATA   = 4'd11;
  localparam logic [3:0] REG_PTRIDX = 4'd12;
  localparam logic [3:0] REG_PTR    = 4'd13;
  localparam logic [3:0] REG_NONE   = 4'hF;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} seq_st_t;

  // Address byte to register select; out-of-range bytes select nothing.
  function automatic logic [3:0] reg_sel(input logic [7:0] b);
    return (b <= 8'd13) ? b[3:0] : REG_NONE;
  endfunction

  // Register address after a data byte at address a.
  function automatic logic [3:0] next_reg(input logic [3:0] a);
    case (a)
      REG_REQ, 4'd7, REG_DATA, REG_PTR, 4'd14, REG_NONE: return a;
      default: return a + 4'd1;
    endcase
  endfunction

  // One cursor step: {row, col}.
  function automatic logic [10:0] cursor_step(input logic [4:0] r, input logic [5:0] c,
                                              input logic [4:0] last_r, input logic [5:0] last_c);
    if (c >= last_c) return {((r >= last_r) ? 5'd0 : r + 5'd1), 6'd0};
    return {r, c + 6'd1};
  endfunction

  // Indexed-byte index step with wrap after the last entry.
  function automatic logic [2:0] idx_step(input logic [2:0] v, input logic [2:0] last);
    return (v >= last) ? 3'd0 : v + 3'd1;
  endfunction

  function automatic logic [7:0] reg_reset(input int i);
    return (i == 5 || i == 6) ? 8'h03 : 8'h00;
  endfunction

  // Stored bits per control slot; slots kept elsewhere store nothing.
  function automatic logic [7:0] reg_mask(input int i);
    if (i == 3 || i == 9 || i == 10 || i == 11) return 8'h00;
    if (i == 8) return 8'h7F;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/regseq_ctlbank.sv
module regseq_ctlbank
  import regseq_pkg::*;
#(
  parameter int NCTL    = 13,
  parameter int REQ_N   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              bump_req,
  input  logic              bump_ptr,
  output logic [NCTL*8-1:0] regs_q
);
  localparam logic [2:0] REQ_LAST = 3'(REQ_N - 1);

  for (genvar i = 0; i < NCTL; i++) begin : g_slot
    localparam logic [7:0] RV   = reg_reset(i);
    localparam logic [7:0] MASK = reg_mask(i);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   q <= RV;
      else if (wr_en && wr_idx == 4'(i))            q <= wr_data & MASK;
      else if (4'(i) == REG_REQIDX && bump_req)     q <= {q[7:3], idx_step(q[2:0], REQ_LAST)};
      else if (4'(i) == REG_PTRIDX && bump_ptr)     q <= {q[7:3], q[2:0] + 3'd1};
    end
    assign regs_q[i*8 +: 8] = q;
  end

endmodule

// File: rtl/regseq_cursor.sv
module regseq_cursor
  import regseq_pkg::*;
#(
  parameter int LAST_ROW = 23,
  parameter int LAST_COL = 39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_row,
  input  logic       ld_col,
  input  logic [7:0] ld_data,
  input  logic       step,
  output logic [4:0] row,
  output logic [5:0] col
);
  localparam logic [4:0] LR = 5'(LAST_ROW);
  localparam logic [5:0] LC = 6'(LAST_COL);

  logic [10:0] nxt;
  assign nxt = cursor_step(row, col, LR, LC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (step) begin
      row <= nxt[10:6];
      col <= nxt[5:0];
    end else begin
      if (ld_row) row <= ld_data[4:0];
      if (ld_col) col <= ld_data[5:0];
    end
  end

endmodule

// File: rtl/regseq_table.sv
module regseq_table #(
  parameter int N       = 8,
  parameter int W       = 7,
  parameter bit RST_IDX = 1'b1,
  parameter int IW      = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [IW-1:0]  idx,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] q_flat
);

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q <= RST_IDX ? W'(e) : '0;
      else if (we && idx == IW'(e))    q <= wdata;
    end
    assign q_flat[e*W +: W] = q;
  end

endmodule

// File: rtl/regseq_top.sv
module regseq_top
  import regseq_pkg::*;
#(
  parameter int LAST_ROW = 23,
  parameter int LAST_COL = 39,
  parameter int REQ_N    = 7,
  parameter int PTR_N    = 8,
  parameter int PTR_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_start,
  input  logic               ev_read,
  input  logic               ev_wr,
  input  logic               ev_rd,
  input  logic               ev_stop,
  input  logic [7:0]         wr_byte,
  output logic [7:0]         rd_byte,
  output logic               busy,
  input  logic [7:0]         status_in,
  output logic               mem_req,
  output logic               mem_we,
  output logic [6:0]         mem_page,
  output logic [4:0]         mem_row,
  output logic [5:0]         mem_col,
  output logic [7:0]         mem_wdata,
  input  logic               mem_ack,
  input  logic [7:0]         mem_rdata,
  output logic               clr_pulse,
  output logic [13*8-1:0]    ctl_q,
  output logic [REQ_N*8-1:0] req_q,
  output logic [PTR_N*PTR_W-1:0] ptr_q
);
  localparam int NCTL = 13;
  localparam int RIW  = $clog2(REQ_N);
  localparam int PIW  = $clog2(PTR_N);

  seq_st_t    st;
  logic       expect_addr;
  logic [3:0] reg_addr;
  logic [7:0] rd_q, wq;
  logic       clr_q;
  logic [NCTL*8-1:0] bank_q;
  logic [4:0] row;
  logic [5:0] col;

  // Named internal events.
  logic idle, addr_wr_ev, data_wr_ev, rd_ev, cur_step, status_mode, data_slot, prefetch;
  logic [3:0] addr_sel;
  logic [PIW-1:0] ptr_idx;
  logic [RIW-1:0] req_idx;

  assign idle        = (st == S_IDLE);
  assign status_mode = bank_q[REG_MODE*8];
  assign addr_sel    = reg_sel(wr_byte);
  assign addr_wr_ev  = ev_wr && idle && expect_addr;
  assign data_wr_ev  = ev_wr && idle && !expect_addr;
  assign rd_ev       = ev_rd && idle;
  assign data_slot   = (reg_addr == REG_DATA) && !status_mode;
  assign cur_step    = (st == S_WR && mem_ack) || (rd_ev && data_slot);
  assign prefetch    = !status_mode &&
                       ((addr_wr_ev && addr_sel == REG_DATA) ||
                        (data_wr_ev && reg_addr == REG_COL));
  assign ptr_idx     = bank_q[REG_PTRIDX*8 +: PIW];
  assign req_idx     = bank_q[REG_REQIDX*8 +: RIW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      expect_addr <= 1'b0;
      reg_addr    <= 4'd0;
      rd_q        <= 8'h00;
      wq          <= 8'h00;
      clr_q       <= 1'b0;
    end else begin
      clr_q <= data_wr_ev && reg_addr == REG_PAGE && wr_byte[7];

      if (ev_start)                    expect_addr <= !ev_read;
      else if (ev_stop || addr_wr_ev)  expect_addr <= 1'b0;

      if (addr_wr_ev)      reg_addr <= addr_sel;
      else if (data_wr_ev) reg_addr <= next_reg(reg_addr);

      case (st)
        S_IDLE: begin
          if (data_wr_ev && data_slot) begin
            st <= S_WR;
            wq <= wr_byte;
          end else if (prefetch || (rd_ev && data_slot)) begin
            st <= S_RD;
          end
        end
        S_WR: if (mem_ack) st <= S_IDLE;
        S_RD: if (mem_ack) begin
          st   <= S_IDLE;
          rd_q <= mem_rdata;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  regseq_ctlbank #(.NCTL(NCTL), .REQ_N(REQ_N)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(data_wr_ev && reg_addr < 4'(NCTL)),
    .wr_idx(reg_addr), .wr_data(wr_byte),
    .bump_req(data_wr_ev && reg_addr == REG_REQ),
    .bump_ptr(data_wr_ev && reg_addr == REG_PTR),
    .regs_q(bank_q)
  );

  regseq_cursor #(.LAST_ROW(LAST_ROW), .LAST_COL(LAST_COL)) u_cur (
    .clk(clk), .rst_n(rst_n),
    .ld_row(data_wr_ev && reg_addr == REG_ROW),
    .ld_col(data_wr_ev && reg_addr == REG_COL),
    .ld_data(wr_byte), .step(cur_step),
    .row(row), .col(col)
  );

  regseq_table #(.N(REQ_N), .W(8), .RST_IDX(1'b0)) u_req (
    .clk(clk), .rst_n(rst_n),
    .we(data_wr_ev && reg_addr == REG_REQ),
    .idx(req_idx), .wdata(wr_byte), .q_flat(req_q)
  );

  regseq_table #(.N(PTR_N), .W(PTR_W), .RST_IDX(1'b1)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .we(data_wr_ev && reg_addr == REG_PTR),
    .idx(ptr_idx), .wdata(wr_byte[PTR_W-1:0]), .q_flat(ptr_q)
  );

  assign rd_byte   = (reg_addr == REG_DATA) ? (status_mode ? status_in : rd_q) : 8'h00;
  assign busy      = !idle;
  assign mem_req   = !idle;
  assign mem_we    = (st == S_WR);
  assign mem_page  = bank_q[REG_PAGE*8 +: 7];
  assign mem_row   = row;
  assign mem_col   = col;
  assign mem_wdata = wq;
  assign clr_pulse = clr_q;

  always_comb begin
    ctl_q = bank_q;
    ctl_q[REG_ROW*8 +: 8] = 8'(row);
    ctl_q[REG_COL*8 +: 8] = 8'(col);
  end

endmodule

// File: rtl/regseq_chk.sv
module regseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req,
  input logic       mem_ack,
  input logic       mem_we,
  input logic [6:0] mem_page,
  input logic [4:0] mem_row,
  input logic [5:0] mem_col,
  input logic [7:0] mem_wdata,
  input logic       clr_pulse,
  input logic       cur_step,
  input logic       data_wr_ev,
  input logic [3:0] reg_addr,
  input logic       status_mode,
  input logic [2:0] ptr_idx
);

  a_r2_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_ev && (reg_addr <= 4'd2 || (reg_addr >= 4'd4 && reg_addr <= 4'd6) ||
                   (reg_addr >= 4'd8 && reg_addr <= 4'd10) || reg_addr == 4'd12)
    |=> reg_addr == $past(reg_addr) + 4'd1);

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_ev && (reg_addr == 4'd3 || reg_addr == 4'd7 || reg_addr == 4'd11 || reg_addr == 4'd13)
    |=> reg_addr == $past(reg_addr));

  a_r5_ptr_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_ev && reg_addr == 4'd13 |=> ptr_idx == $past(ptr_idx) + 3'd1);

  a_r6_cursor_step: assert property (@(posedge clk) disable iff (!rst_n)
    cur_step |=> (mem_col == $past(mem_col) + 6'd1 && mem_row == $past(mem_row)) ||
                 (mem_col == 6'd0 && (mem_row == $past(mem_row) + 5'd1 || mem_row == 5'd0)));

  a_r7_payload_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_page) &&
                            $stable(mem_row) && $stable(mem_col) && $stable(mem_wdata));

  a_r8_status_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_ev && reg_addr == 4'd11 && status_mode |=> !mem_req);

  a_r10_clear_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);

endmodule

bind regseq_top regseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_page(mem_page), .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata),
  .clr_pulse(clr_pulse), .cur_step(cur_step), .data_wr_ev(data_wr_ev),
  .reg_addr(reg_addr), .status_mode(status_mode), .ptr_idx(ptr_idx)
);

// File: tb/regseq_top_bench.sv
module regseq_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_read = 0, ev_wr = 0, ev_rd = 0, ev_stop = 0;
  logic [7:0] wr_byte = 0, status_in = 8'hC6, mem_rdata = 0;
  logic mem_ack = 0;
  logic [7:0] rd_byte, mem_wdata;
  logic busy, mem_req, mem_we, clr_pulse;
  logic [6:0] mem_page;
  logic [4:0] mem_row;
  logic [5:0] mem_col;
  logic [103:0] ctl_q;
  logic [55:0] req_q, ptr_q;

  int checks = 0, errors = 0, nwr = 0, lat = 0, lat_cnt = 0;
  bit done = 0, seen_clr;
  logic [6:0] lw_page; logic [4:0] lw_row; logic [5:0] lw_col; logic [7:0] lw_data;

  always #10 clk = ~clk;

  regseq_top u_regseq_top (.*);

  function automatic logic [7:0] pattern(input int p, input int r, input int c);
    return 8'((p * 3 + r * 40 + c) ^ 8'h5A);
  endfunction

  // Memory model: acknowledges after lat idle cycles, logs writes.
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req) begin
      if (lat_cnt >= lat) begin
        mem_ack = 1'b1;
        lat_cnt = 0;
        mem_rdata = pattern(mem_page, mem_row, mem_col);
        if (mem_we) begin
          lw_page = mem_page; lw_row = mem_row; lw_col = mem_col; lw_data = mem_wdata;
          nwr++;
        end
      end else lat_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start(input logic rd);
    @(negedge clk); ev_start = 1; ev_read = rd;
    @(negedge clk); ev_start = 0; ev_read = 0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_byte = b; ev_wr = 1;
    @(negedge clk); ev_wr = 0; seen_clr = clr_pulse;
    while (busy) @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] b);
    @(negedge clk); b = rd_byte; ev_rd = 1;
    @(negedge clk); ev_rd = 0;
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] cb(input int i);
    return ctl_q[i*8 +: 8];
  endfunction

  // Bench's own cursor model.
  int mr, mc;
  task automatic mstep();
    if (mc >= 39) begin mc = 0; mr = (mr >= 23) ? 0 : mr + 1; end
    else mc++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 13; i++) chk("R1 ctl reset", cb(i), (i == 5 || i == 6) ? 8'h03 : 8'h00);
    for (int i = 0; i < 8; i++)  chk("R1 ptr reset", ptr_q[i*7 +: 7], 7'(i));
    chk("R1 req reset", req_q, 0);
    chk("R1 busy reset", {busy, mem_req, clr_pulse}, 0);

    // R2 advance chain, R3 hold on register 7
    start(0); wr(8'd4); wr(8'h05); wr(8'hA5); wr(8'h5A); wr(8'h11); wr(8'h22); ev_stop = 1; @(negedge clk); ev_stop = 0;
    chk("R2 reg4", cb(4), 8'h05);
    chk("R2 reg5", cb(5), 8'hA5);
    chk("R2 reg6", cb(6), 8'h5A);
    chk("R3 reg7 last byte kept", cb(7), 8'h22);
    chk("R3 reg8 untouched", cb(8), 8'h00);

    // R2 out-of-range address: bytes discarded
    start(0); wr(8'h20); wr(8'hFF); wr(8'hFF);
    for (int i = 0; i < 13; i++) chk("R2 invalid address no effect", cb(i),
      (i == 4) ? 8'h05 : (i == 5) ? 8'hA5 : (i == 6) ? 8'h5A : (i == 7) ? 8'h22 : 8'h00);

    // R10 page register with clear bit
    start(0); wr(8'd8); wr(8'h85);
    chk("R10 clear pulse", seen_clr, 1);
    @(negedge clk);
    chk("R10 clear one cycle", clr_pulse, 0);
    chk("R10 page stored without bit7", cb(8), 8'h05);

    // R6/R7 write sweep across column and row wraps, latency varied
    wr(8'd22); wr(8'd30);
    mr = 22; mc = 30;
    chk("R6 row/col loaded", {cb(9), cb(10)}, {8'd22, 8'd30});
    for (int k = 0; k < 70; k++) begin
      int n0;
      lat = k % 3;
      n0 = nwr;
      wr(8'(k * 7 + 1));
      chk("R7 one write request", nwr - n0, 1);
      chk("R7 write payload", {lw_page, lw_row, lw_col, lw_data},
          {7'd5, 5'(mr), 6'(mc), 8'(k * 7 + 1)});
      mstep();
      chk("R6 cursor after write", {cb(9), cb(10)}, {8'(mr), 8'(mc)});
    end

    // R6 row 24 corner: column wrap from row 24 returns to row 0
    start(0); wr(8'd9); wr(8'd24); wr(8'd39); wr(8'hE1);
    chk("R7 row 24 payload", {lw_row, lw_col, lw_data}, {5'd24, 6'd39, 8'hE1});
    chk("R6 row 24 wraps to 0", {cb(9), cb(10)}, 16'h0000);

    // R9 read sweep with prefetch on address byte 11
    start(0); wr(8'd8); wr(8'h03); wr(8'd23); wr(8'd20);
    start(0); wr(8'd11);
    start(1);
    mr = 23; mc = 20;
    for (int k = 0; k < 60; k++) begin
      lat = (k * 5) % 3;
      rd(b);
      chk("R9 read data", b, pattern(3, mr, mc));
      mstep();
    end
    chk("R9 cursor after reads", {cb(9), cb(10)}, {8'(mr), 8'(mc)});

    // R9 read of a non-data address
    start(0); wr(8'd5); start(1); rd(b);
    chk("R9 other address reads zero", b, 8'h00);

    // R8 status mode
    start(0); wr(8'd0); wr(8'h01);
    start(0); wr(8'd11);
    begin
      int n0; logic [15:0] cur;
      n0 = nwr; cur = {cb(9), cb(10)};
      wr(8'h77); wr(8'h78);
      chk("R8 status write ignored", nwr - n0, 0);
      chk("R8 cursor unchanged", {cb(9), cb(10)}, cur);
    end
    start(1); rd(b);
    chk("R8 status read", b, 8'hC6);
    status_in = 8'h3B; rd(b);
    chk("R8 status read follows input", b, 8'h3B);
    start(0); wr(8'd0); wr(8'h00);

    // R4 request bytes with index wrap and discarded index 7
    start(0); wr(8'd2); wr(8'h05);
    wr(8'hB5); wr(8'hB6); wr(8'hB0); wr(8'hB1);
    chk("R4 index after four writes", cb(2) & 8'h07, 8'h02);
    chk("R4 byte5", req_q[5*8 +: 8], 8'hB5);
    chk("R4 byte6", req_q[6*8 +: 8], 8'hB6);
    chk("R4 byte0", req_q[0*8 +: 8], 8'hB0);
    chk("R4 byte1", req_q[1*8 +: 8], 8'hB1);
    start(0); wr(8'd2); wr(8'h07); wr(8'hEE);
    chk("R4 index 7 write discarded", req_q, {8'hB6, 8'hB5, 8'h00, 8'h00, 8'h00, 8'hB1, 8'hB0});
    chk("R4 index 7 goes to 0", cb(2), 8'h00);

    // R5 pointer table
    start(0); wr(8'd12); wr(8'hF6);
    wr(8'hC0); wr(8'h41); wr(8'h12); wr(8'h13);
    chk("R5 index step keeps upper bits", cb(12), 8'hF2);
    for (int i = 0; i < 8; i++) begin
      logic [6:0] e;
      e = (i == 6) ? 7'h40 : (i == 7) ? 7'h41 : (i == 0) ? 7'h12 : (i == 1) ? 7'h13 : 7'(i);
      chk("R5 pointer entry", ptr_q[i*7 +: 7], e);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule